// File: doc/BRIEF.md
# Scrambling line coder with differential coding

This block is the bit-level line-coding path of a 9600 bit/s FSK modem. On the transmit side it takes 16-bit words through a valid/ready handshake and serialises them least significant bit first, one bit per `bit_tick`. Each bit goes through differential coding, where a zero data bit toggles the coded level and a one keeps it. The coded level is then scrambled multiplicatively with the polynomial 1 + x^12 + x^17 in one 20-bit shift register. The line bit is one bit of that register.

On the receive side every `bit_tick` shifts the line input into a 19-bit history. The block undoes the differential coding, descrambles self-synchronously and packs the recovered bits into 16-bit words, least significant bit first. Each completed word is announced by a one-cycle strobe. Because the descrambler synchronises itself, no framing is needed. After 20 ticks of history, a transmit-to-receive loopback reproduces the transmitted bit stream with a fixed lag.

The transmit side is a two-state machine. State TX_EMPTY holds no word. State TX_LOADED is shifting a word.
- Transition LOAD goes from TX_EMPTY to TX_LOADED when a word is accepted.
- Transition CHAIN stays in TX_LOADED when a new word is accepted on the tick that sends bit 15.
- Transition DRAIN goes from TX_LOADED to TX_EMPTY when bit 15 is sent and no word is offered.

Top module: `scram_nrzi_codec`

## Requirements
- R1: While `rst_n` is low, `tx_line` is 0, `rx_word` is 0, `rx_word_stb` is 0 and `tx_ready` is 1. All shift registers, counters and the transmit state are cleared, and the state is TX_EMPTY.
- R2: `tx_ready` is 1 in TX_EMPTY, and in TX_LOADED on a cycle with `bit_tick` while bit 15 of the current word is being sent. A word is accepted on a rising clock edge with `tx_valid` and `tx_ready` both high. Its bits are sent LSB first, one per tick, starting at the first tick after acceptance.
- R3: A tick that finds no word loaded (TX_EMPTY) sends data bit 1 to the coder.
- R4: On each tick the scrambler register shifts left by one. Bit 0 keeps its old value, and is then inverted when the data bit is 0.
- R5: After that shift, if register bit 18 is 1, register bits 1 and 6 are inverted. `tx_line` is register bit 19 and changes only on the edge that ends a tick cycle.
- R6: On each tick the receive history h shifts left with `rx_line` entering bit 0. With x = h ^ (h >> 1) and y = x ^ (x >> 17) ^ (x >> 12), the recovered bit is the inverse of y bit 0.
- R7: Each recovered bit enters the receive word at bit 15 while the word shifts right. After 16 ticks counted from reset, `rx_word` takes the assembled word and `rx_word_stb` is 1 for exactly the one cycle after that tick edge. At all other times `rx_word` holds its value.
- R8: With `tx_line` wired to `rx_line`, the recovered bit of tick k equals the data bit sent at tick k-20, for every k from 20 onwards after reset.
- R9: Cycles without `bit_tick` change neither `tx_line`, the coder state nor `rx_word`, and they produce no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_tick | input | 1 | One-cycle enable per line bit |
| tx_word | input | 16 | Word to transmit |
| tx_valid | input | 1 | `tx_word` is offered |
| tx_ready | output | 1 | A word is taken at this edge if valid |
| tx_line | output | 1 | Scrambled line bit |
| rx_line | input | 1 | Received line bit |
| rx_word | output | 16 | Last assembled received word |
| rx_word_stb | output | 1 | One-cycle pulse when `rx_word` is new |

## Verification
A wrong scrambler tap or a wrong differential step shows on `tx_line` at the very next tick. Because the register carries the error forward, every later line bit is then suspect too. A descrambler fault corrupts the recovered bits within one word and is reported at the next strobe, at most 16 ticks later. A misaligned word counter shifts the strobe and breaks the 20-tick loopback lag across every later word. A handshake fault drops or repeats a whole word, and the bit-exact line comparison shows this at the first affected tick.

// File: rtl/scram_nrzi_pkg.sv
package scram_nrzi_pkg;

    typedef enum logic {
        TX_EMPTY  = 1'b0,
        TX_LOADED = 1'b1
    } tx_state_e;

    localparam int DEF_WORD_W = 16;
    localparam int DEF_TAP_A  = 17;
    localparam int DEF_TAP_B  = 12;

endpackage

// File: rtl/scram_tx_ser.sv
module scram_tx_ser
    import scram_nrzi_pkg::*;
#(
    parameter int   WORD_W   = 16,
    parameter logic FILL_BIT = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_tick,
    input  logic [WORD_W-1:0] word_in,
    input  logic              word_valid,
    output logic              word_ready,
    output logic              data_bit
);
    localparam int CNT_W = $clog2(WORD_W);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(WORD_W - 1);

    tx_state_e          state_q, state_d;
    logic [WORD_W-1:0]  sh_q;
    logic [CNT_W-1:0]   cnt_q;
    logic               last_bit;
    logic               take;

    assign last_bit   = (cnt_q == LAST_IDX);
    assign word_ready = (state_q == TX_EMPTY) || (bit_tick && last_bit);
    assign take       = word_valid && word_ready;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= TX_EMPTY;
        else        state_q <= state_d;
    end

    // next state: LOAD, CHAIN, DRAIN
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TX_EMPTY: begin
                if (take) state_d = TX_LOADED;
            end
            TX_LOADED: begin
                if (bit_tick && last_bit)
                    state_d = take ? TX_LOADED : TX_EMPTY;
            end
            default: state_d = TX_EMPTY;
        endcase
    end

    // shift register and bit counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q  <= '0;
            cnt_q <= '0;
        end else if (take) begin
            sh_q  <= word_in;
            cnt_q <= '0;
        end else if (bit_tick && state_q == TX_LOADED) begin
            sh_q  <= sh_q >> 1;
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // output process
    always_comb begin
        data_bit = FILL_BIT;
        unique case (state_q)
            TX_EMPTY:  data_bit = FILL_BIT;
            TX_LOADED: data_bit = sh_q[0];
            default:   data_bit = FILL_BIT;
        endcase
    end

    // R2
    empty_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == TX_EMPTY |-> word_ready);

    // R2
    hold_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TX_LOADED && !bit_tick && !take) |=> $stable(sh_q));

endmodule

// File: rtl/scram_coder.sv
module scram_coder #(
    parameter int SCR_W = 20,
    parameter int TAP_A = 17,
    parameter int TAP_B = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_tick,
    input  logic data_bit,
    output logic line_bit
);
    localparam int FB_BIT   = TAP_A + 1;
    localparam int FLIP_LO  = 1;
    localparam int FLIP_HI  = 1 + TAP_A - TAP_B;
    localparam int LINE_IDX = TAP_A + 2;

    logic [SCR_W-1:0] s_q;
    logic [SCR_W-1:0] s_d;

    always_comb begin
        s_d    = {s_q[SCR_W-2:0], s_q[0]};
        s_d[0] = s_d[0] ^ ~data_bit;
        if (s_d[FB_BIT]) begin
            s_d[FLIP_LO] = ~s_d[FLIP_LO];
            s_d[FLIP_HI] = ~s_d[FLIP_HI];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)        s_q <= '0;
        else if (bit_tick) s_q <= s_d;
    end

    assign line_bit = s_q[LINE_IDX];

    // R4
    nrzi_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_tick && data_bit) |=> s_q[0] == $past(s_q[0]));

    // R9
    coder_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_tick |=> $stable(s_q));

endmodule

// File: rtl/scram_decoder.sv
module scram_decoder #(
    parameter int HIST_W = 19,
    parameter int TAP_A  = 17,
    parameter int TAP_B  = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_tick,
    input  logic line_bit,
    output logic data_bit
);
    logic [HIST_W-1:0] h_q;
    logic [HIST_W-1:0] h_n;
    logic [HIST_W-1:0] diff;
    logic [HIST_W-1:0] plain;

    always_comb begin
        h_n      = {h_q[HIST_W-2:0], line_bit};
        diff     = h_n ^ (h_n >> 1);
        plain    = diff ^ (diff >> TAP_A) ^ (diff >> TAP_B);
        data_bit = ~plain[0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n)        h_q <= '0;
        else if (bit_tick) h_q <= h_n;
    end

    // R9
    hist_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_tick |=> $stable(h_q));

    // R6
    hist_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bit_tick |=> h_q[HIST_W-1:1] == $past(h_q[HIST_W-2:0]));

endmodule

// File: rtl/scram_rx_des.sv
module scram_rx_des #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_tick,
    input  logic              data_bit,
    output logic [WORD_W-1:0] word_out,
    output logic              word_stb
);
    localparam int CNT_W = $clog2(WORD_W);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(WORD_W - 1);

    logic [WORD_W-1:0] acc_q;
    logic [WORD_W-1:0] acc_n;
    logic [CNT_W-1:0]  cnt_q;
    logic              last_bit;

    assign acc_n    = {data_bit, acc_q[WORD_W-1:1]};
    assign last_bit = (cnt_q == LAST_IDX);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q    <= '0;
            cnt_q    <= '0;
            word_out <= '0;
            word_stb <= 1'b0;
        end else begin
            word_stb <= 1'b0;
            if (bit_tick) begin
                acc_q <= acc_n;
                cnt_q <= last_bit ? '0 : cnt_q + 1'b1;
                if (last_bit) begin
                    word_out <= acc_n;
                    word_stb <= 1'b1;
                end
            end
        end
    end

    // R7
    stb_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_stb |-> $past(bit_tick));

    // R7
    word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !word_stb |-> $stable(word_out));

endmodule

// File: rtl/scram_nrzi_codec.sv
module scram_nrzi_codec
    import scram_nrzi_pkg::*;
#(
    parameter int   WORD_W   = DEF_WORD_W,
    parameter int   TAP_A    = DEF_TAP_A,
    parameter int   TAP_B    = DEF_TAP_B,
    parameter logic FILL_BIT = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_tick,
    input  logic [WORD_W-1:0] tx_word,
    input  logic              tx_valid,
    output logic              tx_ready,
    output logic              tx_line,
    input  logic              rx_line,
    output logic [WORD_W-1:0] rx_word,
    output logic              rx_word_stb
);
    localparam int SCR_W  = TAP_A + 3;
    localparam int HIST_W = TAP_A + 2;

    logic tx_bit;
    logic rx_bit;

    scram_tx_ser #(.WORD_W(WORD_W), .FILL_BIT(FILL_BIT)) u_tx_ser (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_tick   (bit_tick),
        .word_in    (tx_word),
        .word_valid (tx_valid),
        .word_ready (tx_ready),
        .data_bit   (tx_bit)
    );

    scram_coder #(.SCR_W(SCR_W), .TAP_A(TAP_A), .TAP_B(TAP_B)) u_coder (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_tick (bit_tick),
        .data_bit (tx_bit),
        .line_bit (tx_line)
    );

    scram_decoder #(.HIST_W(HIST_W), .TAP_A(TAP_A), .TAP_B(TAP_B)) u_decoder (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_tick (bit_tick),
        .line_bit (rx_line),
        .data_bit (rx_bit)
    );

    scram_rx_des #(.WORD_W(WORD_W)) u_rx_des (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_tick (bit_tick),
        .data_bit (rx_bit),
        .word_out (rx_word),
        .word_stb (rx_word_stb)
    );

    // R5
    line_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(bit_tick) |-> $stable(tx_line));

    // R9
    no_stb_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(bit_tick) |-> !rx_word_stb);

endmodule

// File: tb/test_scram_nrzi_codec.sv
module test_scram_nrzi_codec;

    localparam int NWORDS = 48;
    localparam int LAG    = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bit_tick = 1'b0;
    logic [15:0] tx_word = '0;
    logic        tx_valid = 1'b0;
    logic        rx_drv = 1'b0;
    logic        loop_en = 1'b0;
    logic        tx_ready, tx_line, rx_line, rx_word_stb;
    logic [15:0] rx_word;

    always #10 clk = ~clk;

    assign rx_line = loop_en ? tx_line : rx_drv;

    scram_nrzi_codec i_scram_nrzi_codec (
        .clk         (clk),
        .rst_n       (rst_n),
        .bit_tick    (bit_tick),
        .tx_word     (tx_word),
        .tx_valid    (tx_valid),
        .tx_ready    (tx_ready),
        .tx_line     (tx_line),
        .rx_line     (rx_line),
        .rx_word     (rx_word),
        .rx_word_stb (rx_word_stb)
    );

    int n_chk = 0;
    int n_fail = 0;

    // bench-side expectations
    logic [19:0] m_s;
    logic [18:0] m_h;
    logic [15:0] m_w, m_last, m_word;
    int          m_rcnt, m_cnt;
    bit          m_busy;
    bit          txbits [0:4095];
    bit          rxbits [0:4095];
    int          ntx, nrx, widx;
    bit          feed_en;

    function automatic logic [15:0] gen_word(input int i);
        case (i)
            0: return 16'h0000;
            1: return 16'hFFFF;
            2: return 16'hAAAA;
            3: return 16'h5555;
            default: return 16'(i * 40503) ^ 16'(1 << (i % 16));
        endcase
    endfunction

    task automatic check(input bit ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_clear();
        m_s = '0; m_h = '0; m_w = '0; m_last = '0; m_word = '0;
        m_rcnt = 0; m_cnt = 0; m_busy = 0; ntx = 0; nrx = 0; widx = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; bit_tick = 1'b0; tx_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        // R1 reset state
        check(tx_line === 1'b0, "R1 tx_line", 32'(tx_line), 0);
        check(rx_word === 16'h0, "R1 rx_word", 32'(rx_word), 0);
        check(rx_word_stb === 1'b0, "R1 rx_word_stb", 32'(rx_word_stb), 0);
        check(tx_ready === 1'b1, "R1 tx_ready", 32'(tx_ready), 1);
        model_clear();
        rst_n = 1'b1;
    endtask

    task automatic step(input bit tk, input bit rb);
        bit          acc;
        logic        dbit, rxin, ob;
        logic [19:0] sh;
        logic [18:0] hn, x, y;
        @(negedge clk);
        tx_valid = feed_en && (widx < NWORDS);
        tx_word  = gen_word(widx);
        bit_tick = tk;
        rx_drv   = rb;
        #1;
        // R2 ready while nothing is loaded
        if (!m_busy) check(tx_ready === 1'b1, "R2 ready", 32'(tx_ready), 1);
        acc  = tx_valid && tx_ready;
        rxin = rx_line;
        @(posedge clk);
        #1;
        if (tk) begin
            dbit = m_busy ? m_word[m_cnt] : 1'b1;
            if (ntx < 4096) txbits[ntx] = dbit;
            ntx++;
            sh = {m_s[18:0], m_s[0]};
            if (!dbit) sh[0] = ~sh[0];
            if (sh[18]) begin sh[1] = ~sh[1]; sh[6] = ~sh[6]; end
            m_s = sh;
            if (m_busy) begin
                if (m_cnt == 15) m_busy = 0;
                else m_cnt++;
            end
            hn = {m_h[17:0], rxin};
            m_h = hn;
            x = hn ^ (hn >> 1);
            y = x ^ (x >> 17) ^ (x >> 12);
            ob = ~y[0];
            m_w = {ob, m_w[15:1]};
            m_rcnt++;
        end
        if (acc) begin
            m_busy = 1; m_word = tx_word; m_cnt = 0; widx++;
        end
        // R3 R4 R5 on tick edges (fill bits when empty), R9 otherwise
        if (tk) check(tx_line === m_s[19], "R3 R4 R5 tx_line", 32'(tx_line), 32'(m_s[19]));
        else    check(tx_line === m_s[19], "R9 tx_line hold", 32'(tx_line), 32'(m_s[19]));
        if (tk && m_rcnt == 16) begin
            m_rcnt = 0;
            m_last = m_w;
            check(rx_word_stb === 1'b1, "R7 strobe", 32'(rx_word_stb), 1);
            check(rx_word === m_w, "R6 R7 rx_word", 32'(rx_word), 32'(m_w));
            for (int b = 0; b < 16; b++) begin
                if (nrx < 4096) rxbits[nrx] = rx_word[b];
                nrx++;
            end
        end else begin
            check(rx_word_stb === 1'b0, "R7 R9 no strobe", 32'(rx_word_stb), 0);
            check(rx_word === m_last, "R9 rx_word hold", 32'(rx_word), 32'(m_last));
        end
    endtask

    initial begin
        #(20 * 150000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        feed_en = 1'b0;
        model_clear();
        // Phase 1: loopback with continuous words, then an underrun gap
        loop_en = 1'b1;
        do_reset();
        feed_en = 1'b1;
        for (int t = 0; t < 960; t++) begin
            if (t == 300) feed_en = 1'b0;   // R3 underrun
            if (t == 340) feed_en = 1'b1;
            step(1'b1, 1'b0);
            for (int g = 0; g < 3; g++) step(1'b0, 1'b0);
        end
        // R8 loopback lag
        for (int k = 2 * LAG; k < nrx && k < 4096; k++)
            check(rxbits[k] == txbits[k - LAG], "R8 loopback", 32'(rxbits[k]), 32'(txbits[k - LAG]));

        // Phase 2: receive path driven directly, ticks every cycle, transmit idle
        loop_en = 1'b0;
        feed_en = 1'b0;
        do_reset();
        begin
            logic [15:0] lfsr;
            lfsr = 16'hACE1;
            for (int t = 0; t < 640; t++) begin
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                step(1'b1, (t < 64) ? 1'b1 : lfsr[0]);
            end
        end
        // tick gaps with receive-only stimulus
        for (int t = 0; t < 64; t++) begin
            step(1'b1, t[1]);
            step(1'b0, ~t[1]);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule